// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block generates the instruction fetch address for a small 8-bit controller. It holds a 13-bit program counter that advances by one on every instruction-cycle strobe. Decoded control pulses from the instruction decoder can instead make it take an absolute jump, take a call (which saves the return address), return from a call or an interrupt, or load its low byte from the data bus. An accepted interrupt request saves the next address, loads the interrupt vector 0x0004 and masks further interrupts. An eight-entry circular return stack is held inside the block.

The top five counter bits are never written directly. They are supplied by a 5-bit holding latch that is loaded from the data bus. Only 2K words of program space exist, so the fetch address is the low 11 counter bits and wraps inside that space. Every change of flow raises a flush flag for the next instruction cycle so the decoder discards the prefetched word.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the counter, fetch address, low-byte view, holding latch, global interrupt enable and flush flag are all zero. A jump with immediate 0x001 taken right after reset lands on 0x0001.
- R2: With `cyc_en` high and no flow request, the counter steps by one and wraps from 0x1FFF to 0x0000. With `cyc_en` low the counter and flush flag hold, whatever the request inputs are.
- R3: `fetch_addr` equals counter bits 10:0. A counter value of 0x0800 fetches word 0x000.
- R4: `hold_wr` loads `dbus[4:0]` into the holding latch. A jump sets counter bits 10:0 to `imm` and bits 12:11 to holding-latch bits 4:3.
- R5: A call pushes the current counter value and then loads the counter as a jump does. `ret_req` (plain return or return with literal) and `reti_req` load the counter from the stack top and pop it.
- R6: The stack is circular with eight entries. After nine calls, nine returns give the last eight pushed values in reverse order and then the ninth-pushed value again. No flag is raised.
- R7: A low-byte write loads `{holding latch[4:0], dbus}` into the counter. `pc_low` always shows counter bits 7:0.
- R8: `irq_req` is taken only while `gie` is 1. Taking it pushes the current counter, loads 0x0004 and clears `gie`. `reti_req` sets `gie`. `gie_wr` loads `gie` from `dbus[7]`.
- R9: Priority, highest first: taken interrupt, call, jump, return/return-from-interrupt, low-byte write. A request that loses does not act, so a call that beats a jump still pushes.
- R10: `flush` is 1 for the instruction cycle after any counter load other than an increment, and 0 after an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe; all state moves only when high |
| jmp_req | input | 1 | Absolute jump |
| call_req | input | 1 | Call: push and jump |
| ret_req | input | 1 | Return or return with literal: pop |
| reti_req | input | 1 | Return from interrupt: pop and set enable |
| lowwr_req | input | 1 | Write counter low byte from data bus |
| hold_wr | input | 1 | Load holding latch from dbus[4:0] |
| gie_wr | input | 1 | Load interrupt enable from dbus[7] |
| irq_req | input | 1 | Interrupt request |
| imm | input | 11 | Jump/call target immediate |
| dbus | input | 8 | Data bus |
| pc | output | 13 | Full program counter |
| fetch_addr | output | 11 | Program memory address |
| pc_low | output | 8 | Counter low byte view |
| gie | output | 1 | Global interrupt enable |
| flush | output | 1 | Discard prefetched instruction |

## Verification
An accepted interrupt and a flow-control instruction can land in the same instruction cycle. The bench provokes this by raising `irq_req` together with `jmp_req` while interrupts are enabled. It judges the result by the counter reaching 0x0004 rather than the jump target, and by a later return-from-interrupt restoring the address that was current before the interrupt. A call paired with a jump is a second same-cycle case; it is judged by a return that goes back to the pushed address.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_IRQ  = 3'd1,
    SEL_CALL = 3'd2,
    SEL_JMP  = 3'd3,
    SEL_POP  = 3'd4,
    SEL_LOW  = 3'd5
  } pc_sel_e;
endpackage

// File: rtl/pcs_return_stack.sv
module pcs_return_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;

  always_comb begin
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    ptr_d   = ptr_q;
    if (push)     ptr_d = ptr_inc;
    else if (pop) ptr_d = ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= din;
  end

  assign dout = mem[ptr_dec];

  AST_TOS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> dout == $past(din)); // R5
  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R9
endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int IMM_W  = 11,
  parameter int DATA_W = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic                 take_irq,
  input  logic                 call_req,
  input  logic                 jmp_req,
  input  logic                 ret_req,
  input  logic                 reti_req,
  input  logic                 lowwr_req,
  input  logic [PC_W-1:0]      pc_q,
  input  logic [PC_W-DATA_W-1:0] hold_q,
  input  logic [IMM_W-1:0]     imm,
  input  logic [DATA_W-1:0]    dbus,
  input  logic [PC_W-1:0]      pop_data,
  output pc_sel_e              sel,
  output logic [PC_W-1:0]      pc_nxt,
  output logic                 push,
  output logic                 pop,
  output logic                 reti_taken,
  output logic                 flow_chg
);
  localparam int HOLD_W = PC_W - DATA_W;
  localparam int UP_W   = PC_W - IMM_W;

  logic [PC_W-1:0] jmp_tgt;
  assign jmp_tgt = {hold_q[HOLD_W-1 -: UP_W], imm};

  always_comb begin
    if (take_irq)                  sel = SEL_IRQ;
    else if (call_req)             sel = SEL_CALL;
    else if (jmp_req)              sel = SEL_JMP;
    else if (ret_req || reti_req)  sel = SEL_POP;
    else if (lowwr_req)            sel = SEL_LOW;
    else                           sel = SEL_INC;
  end

  always_comb begin
    unique case (sel)
      SEL_IRQ:  pc_nxt = IRQ_VEC;
      SEL_CALL: pc_nxt = jmp_tgt;
      SEL_JMP:  pc_nxt = jmp_tgt;
      SEL_POP:  pc_nxt = pop_data;
      SEL_LOW:  pc_nxt = {hold_q, dbus};
      default:  pc_nxt = pc_q + 1'b1;
    endcase
  end

  assign push       = (sel == SEL_IRQ) || (sel == SEL_CALL);
  assign pop        = (sel == SEL_POP);
  assign reti_taken = (sel == SEL_POP) && reti_req;
  assign flow_chg   = (sel != SEL_INC);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int IMPL_W = 11,
  parameter int IMM_W  = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              jmp_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              reti_req,
  input  logic              lowwr_req,
  input  logic              hold_wr,
  input  logic              gie_wr,
  input  logic              irq_req,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] dbus,
  output logic [PC_W-1:0]   pc,
  output logic [IMPL_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] pc_low,
  output logic              gie,
  output logic              flush
);
  localparam int HOLD_W = PC_W - DATA_W;

  logic [PC_W-1:0]   pc_q, pc_d, pc_nxt, pop_data;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              gie_q, gie_d, flush_q, flush_d;
  logic              take_irq, push_c, pop_c, reti_taken, flow_chg;
  pc_sel_e           sel;

  assign take_irq = irq_req && gie_q;

  pcs_next_addr #(
    .PC_W(PC_W), .IMM_W(IMM_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .take_irq  (take_irq),
    .call_req  (call_req),
    .jmp_req   (jmp_req),
    .ret_req   (ret_req),
    .reti_req  (reti_req),
    .lowwr_req (lowwr_req),
    .pc_q      (pc_q),
    .hold_q    (hold_q),
    .imm       (imm),
    .dbus      (dbus),
    .pop_data  (pop_data),
    .sel       (sel),
    .pc_nxt    (pc_nxt),
    .push      (push_c),
    .pop       (pop_c),
    .reti_taken(reti_taken),
    .flow_chg  (flow_chg)
  );

  pcs_return_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .push (cyc_en && push_c),
    .pop  (cyc_en && pop_c),
    .din  (pc_q),
    .dout (pop_data)
  );

  always_comb begin
    pc_d    = pc_q;
    hold_d  = hold_q;
    gie_d   = gie_q;
    flush_d = flush_q;
    if (cyc_en) begin
      pc_d    = pc_nxt;
      flush_d = flow_chg;
      if (hold_wr) hold_d = dbus[HOLD_W-1:0];
      if (take_irq)        gie_d = 1'b0;
      else if (reti_taken) gie_d = 1'b1;
      else if (gie_wr)     gie_d = dbus[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      hold_q  <= '0;
      gie_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      hold_q  <= hold_d;
      gie_q   <= gie_d;
      flush_q <= flush_d;
    end
  end

  assign pc         = pc_q;
  assign fetch_addr = pc_q[IMPL_W-1:0];
  assign pc_low     = pc_q[DATA_W-1:0];
  assign gie        = gie_q;
  assign flush      = flush_q;

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(pc) && $stable(flush)); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && !(jmp_req || call_req || ret_req || reti_req || lowwr_req) && !(irq_req && gie)
    |=> pc == $past(pc) + 1'b1 && !flush); // R2
  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && irq_req && gie |=> pc == IRQ_VEC && !gie && flush); // R8
  AST_JMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && jmp_req && !call_req && !(irq_req && gie) |=> pc[IMM_W-1:0] == $past(imm)); // R4
  AST_FLUSH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && (jmp_req || call_req || ret_req || reti_req || lowwr_req) |=> flush); // R10
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  logic clk, rst_n, cyc_en;
  logic jmp_req, call_req, ret_req, reti_req, lowwr_req, hold_wr, gie_wr, irq_req;
  logic [10:0] imm;
  logic [7:0]  dbus;
  logic [12:0] pc;
  logic [10:0] fetch_addr;
  logic [7:0]  pc_low;
  logic        gie, flush;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
    .jmp_req(jmp_req), .call_req(call_req), .ret_req(ret_req), .reti_req(reti_req),
    .lowwr_req(lowwr_req), .hold_wr(hold_wr), .gie_wr(gie_wr), .irq_req(irq_req),
    .imm(imm), .dbus(dbus), .pc(pc), .fetch_addr(fetch_addr), .pc_low(pc_low),
    .gie(gie), .flush(flush)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [7:0] C_JMP = 8'h01, C_CALL = 8'h02, C_RET = 8'h04, C_RETI = 8'h08,
                         C_LOW = 8'h10, C_HOLD = 8'h20, C_GIE = 8'h40, C_IRQ = 8'h80;

  // {op[2:0], irq, imm[10:0], dbus[7:0], exp_pc[12:0], exp_flush, exp_gie}
  // op: 0 none, 1 jump, 2 call, 3 return, 4 low write, 5 hold write, 6 enable write, 7 reti
  localparam logic [37:0] VEC [14] = '{
    {3'd0, 1'b0, 11'h000, 8'h00, 13'h0001, 1'b0, 1'b0},
    {3'd0, 1'b0, 11'h000, 8'h00, 13'h0002, 1'b0, 1'b0},
    {3'd5, 1'b0, 11'h000, 8'h1B, 13'h0003, 1'b0, 1'b0},
    {3'd1, 1'b0, 11'h123, 8'h00, 13'h1923, 1'b1, 1'b0},
    {3'd0, 1'b0, 11'h000, 8'h00, 13'h1924, 1'b0, 1'b0},
    {3'd2, 1'b0, 11'h055, 8'h00, 13'h1855, 1'b1, 1'b0},
    {3'd4, 1'b0, 11'h000, 8'hA0, 13'h1BA0, 1'b1, 1'b0},
    {3'd3, 1'b0, 11'h000, 8'h00, 13'h1924, 1'b1, 1'b0},
    {3'd6, 1'b0, 11'h000, 8'h80, 13'h1925, 1'b0, 1'b1},
    {3'd0, 1'b1, 11'h000, 8'h00, 13'h0004, 1'b1, 1'b0},
    {3'd0, 1'b1, 11'h000, 8'h00, 13'h0005, 1'b0, 1'b0},
    {3'd7, 1'b0, 11'h000, 8'h00, 13'h1925, 1'b1, 1'b1},
    {3'd1, 1'b1, 11'h7FF, 8'h00, 13'h0004, 1'b1, 1'b0},
    {3'd7, 1'b0, 11'h000, 8'h00, 13'h1925, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] ctl, input logic [10:0] im,
                      input logic [7:0] db);
    @(negedge clk);
    cyc_en = en;
    jmp_req = ctl[0]; call_req = ctl[1]; ret_req = ctl[2]; reti_req = ctl[3];
    lowwr_req = ctl[4]; hold_wr = ctl[5]; gie_wr = ctl[6]; irq_req = ctl[7];
    imm = im; dbus = db;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc_en = 0; jmp_req = 0; call_req = 0; ret_req = 0; reti_req = 0;
    lowwr_req = 0; hold_wr = 0; gie_wr = 0; irq_req = 0; imm = '0; dbus = '0;
    repeat (3) @(negedge clk);
    chk("R1 pc", 16'(pc), 16'h0);
    chk("R1 fetch", 16'(fetch_addr), 16'h0);
    chk("R1 pc_low", 16'(pc_low), 16'h0);
    chk("R1 gie", 16'(gie), 16'h0);
    chk("R1 flush", 16'(flush), 16'h0);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] op_ctl(input logic [2:0] op);
    case (op)
      3'd1: return C_JMP;
      3'd2: return C_CALL;
      3'd3: return C_RET;
      3'd4: return C_LOW;
      3'd5: return C_HOLD;
      3'd6: return C_GIE;
      3'd7: return C_RETI;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string op_tag(input logic [2:0] op, input logic irq);
    if (irq && op != 3'd0) return "R9";
    if (irq) return "R8";
    case (op)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R4";
      3'd6: return "R8";
      3'd7: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int i = 0; i < 14; i++) begin
      logic [37:0] v;
      string t;
      v = VEC[i];
      t = op_tag(v[37:35], v[34]);
      step(1'b1, op_ctl(v[37:35]) | (v[34] ? C_IRQ : 8'h00), v[33:23], v[22:15]);
      chk({t, " pc"}, 16'(pc), 16'(v[14:2]));
      chk({t, " flush R10"}, 16'(flush), 16'(v[1]));
      chk({t, " gie"}, 16'(gie), 16'(v[0]));
      chk("R3 fetch", 16'(fetch_addr), 16'(v[12:2]));
    end

    // R2: no strobe, requests ignored
    step(1'b0, C_JMP | C_LOW, 11'h3AA, 8'h55);
    step(1'b0, C_JMP, 11'h3AA, 8'h55);
    chk("R2 stall pc", 16'(pc), 16'h1925);
    chk("R2 stall flush", 16'(flush), 16'h1);

    // R9: call beats jump, still pushes
    step(1'b1, C_CALL | C_JMP, 11'h200, 8'h00);
    chk("R9 call wins", 16'(pc), 16'h1A00);
    step(1'b1, C_RET, 11'h000, 8'h00);
    chk("R9 pushed ret", 16'(pc), 16'h1925);

    // R3: fetch wraps inside 2K
    step(1'b1, C_HOLD, 11'h000, 8'h08);
    step(1'b1, C_LOW, 11'h000, 8'h00);
    chk("R3 pc 0800", 16'(pc), 16'h0800);
    chk("R3 fetch wrap", 16'(fetch_addr), 16'h000);
    chk("R7 pc_low", 16'(pc_low), 16'h00);

    // R2: 13-bit wrap
    step(1'b1, C_HOLD, 11'h000, 8'h1F);
    step(1'b1, C_LOW, 11'h000, 8'hFF);
    chk("R7 low write", 16'(pc), 16'h1FFF);
    chk("R7 pc_low", 16'(pc_low), 16'hFF);
    step(1'b1, 8'h00, 11'h000, 8'h00);
    chk("R2 wrap", 16'(pc), 16'h0000);
    chk("R10 no flush on inc", 16'(flush), 16'h0);

    // R8: interrupt ignored while disabled
    step(1'b1, C_GIE, 11'h000, 8'h00);
    chk("R8 gie cleared", 16'(gie), 16'h0);
    step(1'b1, C_IRQ, 11'h000, 8'h00);
    chk("R8 irq masked pc", 16'(pc), 16'h0002);
    chk("R8 irq masked flush", 16'(flush), 16'h0);

    // R1: holding latch cleared by reset
    do_reset();
    step(1'b1, C_JMP, 11'h001, 8'h00);
    chk("R1 hold zero", 16'(pc), 16'h0001);

    // R6: circular stack, nine calls then nine returns
    for (int k = 0; k < 9; k++) step(1'b1, C_CALL, 11'(11'h100 + k), 8'h00);
    for (int k = 0; k < 8; k++) begin
      step(1'b1, C_RET, 11'h000, 8'h00);
      chk("R6 pop order", 16'(pc), 16'(13'h107 - k));
    end
    step(1'b1, C_RET, 11'h000, 8'h00);
    chk("R6 ninth pop wraps", 16'(pc), 16'h0107);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule